// File: doc/BRIEF.md
# Zero-Address Stack Arithmetic Engine

This block executes a stream of stack-machine commands against a small on-chip stack of 32-bit words. Commands carry no operand addresses for the arithmetic: every dyadic operation reads the top two entries, writes its result into the lower of the two and shrinks the stack by one entry. A monadic bit inversion rewrites the top entry in place. Values enter the stack either as an immediate carried by the command or by a read from an external synchronous memory. They leave the stack by a pop that writes to that memory.

The stack pointer `tos_addr` is a byte address that moves in steps of four, one step per 32-bit entry. It holds the byte address of the current top entry. An empty stack is shown as the position one step below entry zero, which is 7'h7C in the default 7-bit pointer. A command that would overrun a full stack, or that finds too few operands, is consumed without any effect and latches a sticky error flag. Only reset clears these flags.

Top module: `zstk_engine`

## Requirements
- R1: After reset, `tos_addr` is 7'h7C (empty), `top_data` is 0, `err_ovf` and `err_unf` are 0, and `cmd_ready` is 1.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. Opcode 0 (push immediate) places `cmd_data` on top and advances `tos_addr` by 4 at that edge, and `cmd_ready` stays 1.
- R3: Opcode 1 (push from memory) drives `mem_req`=1, `mem_we`=0 and `mem_addr`=`cmd_data` in its accept cycle. `cmd_ready` is 0 for exactly the next cycle. The word that the memory returns in that cycle then becomes the top, and `tos_addr` advances by 4.
- R4: Opcode 2 (pop to memory) drives `mem_req`=1, `mem_we`=1, `mem_addr`=`cmd_data` and `mem_wdata`=top entry in its accept cycle, and retreats `tos_addr` by 4.
- R5: Opcodes 3 (add), 4 (subtract), 5 (and) and 6 (or) compute `top op second`, where subtract is top minus second. The result is written over the second entry and `tos_addr` retreats by 4.
- R6: Opcode 7 (not) replaces the top entry with its bitwise inverse and leaves `tos_addr` unchanged.
- R7: A push of either kind at 16 entries is refused. It sets `err_ovf` and touches neither memory nor stack nor pointer. `err_ovf` stays set until reset.
- R8: A dyadic op with fewer than two entries, or a pop or not on an empty stack, is refused. It sets `err_unf` and touches neither memory nor stack nor pointer. `err_unf` stays set until reset.
- R9: The sequence push-from-memory A, push-from-memory B, add, pop to C leaves A+B at C and the stack at its starting depth.
- R10: No command is taken while `cmd_ready` is 0, and no memory request is issued in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command this cycle |
| cmd_op | input | 3 | Opcode (encoding in R2 to R6) |
| cmd_data | input | 32 | Immediate value or memory byte address |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write (pop), 0 = read (push) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Word written on pop |
| mem_rdata | input | 32 | Read word, valid the cycle after the request |
| tos_addr | output | 7 | Byte address of the top entry; 7'h7C when empty |
| top_data | output | 32 | Current top entry, 0 when empty |
| err_ovf | output | 1 | Sticky overflow flag |
| err_unf | output | 1 | Sticky underflow flag |

## Verification
The one overlap in time that matters is a push from memory whose fill cycle coincides with a new command that is already waiting. The bench keeps `cmd_valid` high through the busy cycle and switches the offered command to an immediate push with a marker value. It then judges that the top word is the memory word and the depth grew by one entry, not two. A second overlap pairs refusal with acceptance: at the stack limits a refused command is still consumed. The bench confirms at the ports that the pointer and top are unchanged, that no memory strobe appeared, and that the flag persists across later successful commands.

// File: rtl/zstk_pkg.sv
package zstk_pkg;

    localparam int ZS_DATA_W = 32;
    localparam int ZS_DEPTH  = 16;
    localparam int ZS_ADDR_W = 32;

    typedef enum logic [2:0] {
        OP_PUSH_IMM = 3'd0,
        OP_PUSH_MEM = 3'd1,
        OP_POP_MEM  = 3'd2,
        OP_ADD      = 3'd3,
        OP_SUB      = 3'd4,
        OP_AND      = 3'd5,
        OP_OR       = 3'd6,
        OP_NOT      = 3'd7
    } zs_op_e;

    typedef enum logic {
        ST_IDLE,
        ST_FILL
    } zs_state_e;

    typedef enum logic [1:0] {
        WS_IMM,
        WS_MEM,
        WS_ALU
    } zs_wsel_e;

    function automatic logic zs_is_dyadic(zs_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) || (op == OP_OR);
    endfunction

endpackage

// File: rtl/zstk_alu.sv
module zstk_alu
    import zstk_pkg::*;
#(
    parameter int DATA_W = ZS_DATA_W
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res
);

    always_comb begin
        unique case (zs_op_e'(op))
            OP_ADD:  res = opa + opb;
            OP_SUB:  res = opa - opb;
            OP_AND:  res = opa & opb;
            OP_OR:   res = opa | opb;
            OP_NOT:  res = ~opa;
            default: res = opa;
        endcase
    end

endmodule

// File: rtl/zstk_store.sv
module zstk_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data
);

    logic [DATA_W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (wr_en) begin
            slot_q[wr_idx] <= wr_data;
        end
    end

    assign rd_a_data = slot_q[rd_a_idx];
    assign rd_b_data = slot_q[rd_b_idx];

endmodule

// File: rtl/zstk_ctrl.sv
module zstk_ctrl
    import zstk_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int BYTES  = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LSB   = $clog2(BYTES),
    localparam int PTR_W = $clog2(DEPTH * BYTES) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    output logic             cmd_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output zs_wsel_e         wr_sel,
    output logic [IDX_W-1:0] top_idx,
    output logic [IDX_W-1:0] sec_idx,
    output logic             empty,
    output logic [PTR_W-1:0] tos_q,
    output logic             ovf_q,
    output logic             unf_q
);

    localparam logic [PTR_W-1:0] STEP      = PTR_W'(BYTES);
    localparam logic [PTR_W-1:0] TOS_EMPTY = {PTR_W{1'b0}} - STEP;
    localparam logic [PTR_W-1:0] TOS_FULL  = PTR_W'((DEPTH - 1) * BYTES);

    zs_state_e        st_q, st_d;
    logic [PTR_W-1:0] tos_d;
    logic             ovf_d, unf_d;
    logic             full, has_two;
    logic [IDX_W-1:0] push_idx;
    zs_op_e           op;

    assign op       = zs_op_e'(cmd_op);
    assign top_idx  = tos_q[LSB +: IDX_W];
    assign sec_idx  = top_idx - IDX_W'(1);
    assign push_idx = top_idx + IDX_W'(1);
    assign empty    = (tos_q == TOS_EMPTY);
    assign full     = (tos_q == TOS_FULL);
    assign has_two  = !empty && (tos_q != '0);

    always_comb begin
        st_d      = st_q;
        tos_d     = tos_q;
        ovf_d     = ovf_q;
        unf_d     = unf_q;
        wr_en     = 1'b0;
        wr_idx    = top_idx;
        wr_sel    = WS_ALU;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        cmd_ready = (st_q == ST_IDLE);

        if (st_q == ST_FILL) begin
            wr_en  = 1'b1;
            wr_idx = push_idx;
            wr_sel = WS_MEM;
            tos_d  = tos_q + STEP;
            st_d   = ST_IDLE;
        end else if (cmd_valid) begin
            unique case (op)
                OP_PUSH_IMM: begin
                    if (full) ovf_d = 1'b1;
                    else begin
                        wr_en  = 1'b1;
                        wr_idx = push_idx;
                        wr_sel = WS_IMM;
                        tos_d  = tos_q + STEP;
                    end
                end
                OP_PUSH_MEM: begin
                    if (full) ovf_d = 1'b1;
                    else begin
                        mem_req = 1'b1;
                        st_d    = ST_FILL;
                    end
                end
                OP_POP_MEM: begin
                    if (empty) unf_d = 1'b1;
                    else begin
                        mem_req = 1'b1;
                        mem_we  = 1'b1;
                        tos_d   = tos_q - STEP;
                    end
                end
                OP_NOT: begin
                    if (empty) unf_d = 1'b1;
                    else begin
                        wr_en  = 1'b1;
                        wr_idx = top_idx;
                    end
                end
                default: begin
                    if (!has_two) unf_d = 1'b1;
                    else if (zs_is_dyadic(op)) begin
                        wr_en  = 1'b1;
                        wr_idx = sec_idx;
                        tos_d  = tos_q - STEP;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            tos_q <= TOS_EMPTY;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            tos_q <= tos_d;
            ovf_q <= ovf_d;
            unf_q <= unf_d;
        end
    end

endmodule

// File: rtl/zstk_engine.sv
module zstk_engine
    import zstk_pkg::*;
#(
    parameter int DATA_W  = ZS_DATA_W,
    parameter int DEPTH   = ZS_DEPTH,
    parameter int ADDR_W  = ZS_ADDR_W,
    localparam int BYTES  = DATA_W / 8,
    localparam int PTR_W  = $clog2(DEPTH * BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [PTR_W-1:0]  tos_addr,
    output logic [DATA_W-1:0] top_data,
    output logic              err_ovf,
    output logic              err_unf
);

    localparam int IDX_W = $clog2(DEPTH);

    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx, top_idx, sec_idx;
    zs_wsel_e          wr_sel;
    logic              empty;
    logic [DATA_W-1:0] wr_data, top_word, sec_word, alu_res;

    zstk_ctrl #(
        .DEPTH (DEPTH),
        .BYTES (BYTES)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_ready (cmd_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_sel    (wr_sel),
        .top_idx   (top_idx),
        .sec_idx   (sec_idx),
        .empty     (empty),
        .tos_q     (tos_addr),
        .ovf_q     (err_ovf),
        .unf_q     (err_unf)
    );

    zstk_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_a_idx  (top_idx),
        .rd_a_data (top_word),
        .rd_b_idx  (sec_idx),
        .rd_b_data (sec_word)
    );

    zstk_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op  (cmd_op),
        .opa (top_word),
        .opb (sec_word),
        .res (alu_res)
    );

    always_comb begin
        unique case (wr_sel)
            WS_IMM:  wr_data = cmd_data;
            WS_MEM:  wr_data = mem_rdata;
            default: wr_data = alu_res;
        endcase
    end

    assign mem_addr  = cmd_data[ADDR_W-1:0];
    assign mem_wdata = top_word;
    assign top_data  = empty ? '0 : top_word;

endmodule

// File: rtl/zstk_engine_chk.sv
module zstk_engine_chk #(
    parameter int PTR_W = 7,
    parameter int BYTES = 4,
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_ready,
    input logic             mem_req,
    input logic             mem_we,
    input logic [PTR_W-1:0] tos_addr,
    input logic             err_ovf,
    input logic             err_unf
);

    localparam logic [PTR_W-1:0] STEP      = PTR_W'(BYTES);
    localparam logic [PTR_W-1:0] TOS_EMPTY = {PTR_W{1'b0}} - STEP;
    localparam logic [PTR_W-1:0] TOS_FULL  = PTR_W'((DEPTH - 1) * BYTES);

    p_tos_legal_r1: assert property (@(posedge clk) disable iff (rst)
        (tos_addr == TOS_EMPTY) || ((tos_addr % STEP) == '0 && tos_addr <= TOS_FULL));

    p_read_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> !cmd_ready);

    p_busy_single_r3: assert property (@(posedge clk) disable iff (rst)
        !cmd_ready |=> cmd_ready);

    p_fill_advance_r3: assert property (@(posedge clk) disable iff (rst)
        !cmd_ready |=> tos_addr == PTR_W'($past(tos_addr) + STEP));

    p_pop_retreat_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=> tos_addr == PTR_W'($past(tos_addr) - STEP));

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        err_ovf |=> err_ovf);

    p_unf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        err_unf |=> err_unf);

    p_no_mem_busy_r10: assert property (@(posedge clk) disable iff (rst)
        !cmd_ready |-> !mem_req);

endmodule

bind zstk_engine zstk_engine_chk #(
    .PTR_W (PTR_W),
    .BYTES (BYTES),
    .DEPTH (DEPTH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_ready (cmd_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .tos_addr  (tos_addr),
    .err_ovf   (err_ovf),
    .err_unf   (err_unf)
);

// File: tb/zstk_engine_tb.sv
module zstk_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = 3'd0;
    logic [31:0] cmd_data = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [6:0]  tos_addr;
    logic [31:0] top_data;
    logic        err_ovf, err_unf;

    int n_run  = 0;
    int n_fail = 0;

    logic [31:0] bmem [16];
    logic [31:0] ms [16];
    int          cnt;
    logic        e_ovf, e_unf;

    always #10 clk = ~clk;

    zstk_engine u_dut (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .tos_addr  (tos_addr),
        .top_data  (top_data),
        .err_ovf   (err_ovf),
        .err_unf   (err_unf)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) bmem[mem_addr[5:2]] <= mem_wdata;
            else        mem_rdata <= bmem[mem_addr[5:2]];
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_tos();
        return (cnt == 0) ? 7'h7C : 7'((cnt - 1) * 4);
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cnt = 0;
        e_ovf = 1'b0;
        e_unf = 1'b0;
    endtask

    task automatic check_state(input string tag);
        check({tag, " tos"}, 32'(tos_addr), 32'(exp_tos()));
        check({tag, " top"}, top_data, (cnt == 0) ? 32'h0 : ms[cnt-1]);
        check({tag, " ovf"}, 32'(err_ovf), 32'(e_ovf));
        check({tag, " unf"}, 32'(err_unf), 32'(e_unf));
    endtask

    task automatic step(input logic [2:0] op, input logic [31:0] data);
        logic        r_req, r_we;
        logic [31:0] r_addr, r_wd;
        logic [31:0] a, b, f;
        bit          refused;
        string       tag;
        refused = 1'b0;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = data;
        #1;
        r_req  = mem_req;
        r_we   = mem_we;
        r_addr = mem_addr;
        r_wd   = mem_wdata;
        @(negedge clk);
        cmd_valid = 1'b0;
        case (op)
            3'd0: begin
                tag = "R2";
                if (cnt == 16) begin refused = 1'b1; e_ovf = 1'b1; tag = "R7"; end
                else begin
                    check("R2 ready stays", 32'(cmd_ready), 32'd1);
                    ms[cnt] = data;
                    cnt++;
                end
            end
            3'd1: begin
                tag = "R3";
                if (cnt == 16) begin refused = 1'b1; e_ovf = 1'b1; tag = "R7"; end
                else begin
                    check("R3 req", 32'(r_req), 32'd1);
                    check("R3 we", 32'(r_we), 32'd0);
                    check("R3 addr", r_addr, data);
                    check("R3 busy", 32'(cmd_ready), 32'd0);
                    @(negedge clk);
                    check("R3 ready back", 32'(cmd_ready), 32'd1);
                    ms[cnt] = bmem[data[5:2]];
                    cnt++;
                end
            end
            3'd2: begin
                tag = "R4";
                if (cnt == 0) begin refused = 1'b1; e_unf = 1'b1; tag = "R8"; end
                else begin
                    check("R4 req", 32'(r_req), 32'd1);
                    check("R4 we", 32'(r_we), 32'd1);
                    check("R4 addr", r_addr, data);
                    check("R4 wdata", r_wd, ms[cnt-1]);
                    cnt--;
                end
            end
            3'd7: begin
                tag = "R6";
                if (cnt == 0) begin refused = 1'b1; e_unf = 1'b1; tag = "R8"; end
                else ms[cnt-1] = ~ms[cnt-1];
            end
            default: begin
                tag = "R5";
                if (cnt < 2) begin refused = 1'b1; e_unf = 1'b1; tag = "R8"; end
                else begin
                    a = ms[cnt-1];
                    b = ms[cnt-2];
                    case (op)
                        3'd3:    f = a + b;
                        3'd4:    f = a - b;
                        3'd5:    f = a & b;
                        default: f = a | b;
                    endcase
                    ms[cnt-2] = f;
                    cnt--;
                end
            end
        endcase
        if (refused) check({tag, " refused no mem"}, 32'(r_req), 32'd0);
        check_state(tag);
    endtask

    logic [31:0] vals [7];

    initial begin
        for (int k = 0; k < 16; k++) bmem[k] = 32'hC0DE_0000 + 32'(k) * 32'h0101_0101;
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
        vals[3] = 32'h8000_0000; vals[4] = 32'h7FFF_FFFF; vals[5] = 32'h1234_5678;
        vals[6] = 32'hA5A5_A5A5;

        do_reset();
        check("R1 tos", 32'(tos_addr), 32'h7C);
        check("R1 top", top_data, 32'h0);
        check("R1 ovf", 32'(err_ovf), 32'd0);
        check("R1 unf", 32'(err_unf), 32'd0);
        check("R1 ready", 32'(cmd_ready), 32'd1);

        // R8: every refusal kind on an empty stack, memory untouched
        step(3'd2, 32'h0000_0004);
        check("R8 mem kept", bmem[1], 32'hC0DE_0000 + 32'h0101_0101);
        step(3'd7, 32'h0);
        step(3'd3, 32'h0);
        do_reset();

        // R9: A + B from memory lands at C, depth restored
        step(3'd1, 32'h0000_0008);
        step(3'd1, 32'h0000_000C);
        step(3'd3, 32'h0);
        step(3'd2, 32'h0000_0028);
        @(negedge clk);
        check("R9 mem result", bmem[10],
              (32'hC0DE_0000 + 32'd2 * 32'h0101_0101) + (32'hC0DE_0000 + 32'd3 * 32'h0101_0101));
        check("R9 depth", 32'(tos_addr), 32'h7C);

        // R5 / R6: sweep of operand pairs over every ALU opcode
        for (int op = 3; op <= 6; op++) begin
            for (int i = 0; i < 7; i++) begin
                for (int j = 0; j < 7; j++) begin
                    step(3'd0, vals[i]);
                    step(3'd0, vals[j]);
                    step(3'(op), 32'h0);
                    step(3'd2, 32'h0000_0030);
                end
            end
        end
        for (int i = 0; i < 7; i++) begin
            step(3'd0, vals[i]);
            step(3'd7, 32'h0);
            step(3'd2, 32'h0000_0034);
        end

        // R10: a command held through the fill cycle is not taken early
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 3'd1;
        cmd_data  = 32'h0000_0014;
        @(negedge clk);
        check("R10 busy", 32'(cmd_ready), 32'd0);
        cmd_op   = 3'd0;
        cmd_data = 32'hDEAD_BEEF;
        #1;
        check("R10 no req", 32'(mem_req), 32'd0);
        @(negedge clk);
        cmd_valid = 1'b0;
        ms[cnt] = bmem[5];
        cnt++;
        check_state("R10");

        // R7: fill to 16 entries with both push kinds, then overrun
        do_reset();
        for (int k = 0; k < 16; k++) begin
            if (k % 2 == 0) step(3'd0, 32'(k * 3 + 1));
            else            step(3'd1, 32'(k * 4));
        end
        step(3'd0, 32'h5555_5555);
        step(3'd1, 32'h0000_0000);
        // R7 sticky through legal work, then R8 at one entry
        for (int k = 0; k < 15; k++) step(3'd2, 32'h0000_0038);
        step(3'd4, 32'h0);
        step(3'd7, 32'h0);
        step(3'd2, 32'h0000_003C);
        step(3'd2, 32'h0000_003C);
        step(3'd7, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule